// File: doc/BRIEF.md
# Serial-Loaded Switch Control Latch

This block is a serial slave that receives an eight-bit control word over a three-wire link (select, clock, data) and drives eight independent switch-enable outputs. Each enable is controlled by its own bit, so no channel, one channel, several channels or all of them can be on together. The serial pins are brought into a faster system clock through two-flop synchronizers, and their edges are detected there. The system clock must run at least eight times faster than the serial clock, and each serial data bit must be stable for several system clocks around the rising serial clock edge.

While select is low, each rising serial clock edge shifts one data bit into an eight-bit shift register, first bit in at the top. The enable outputs keep their old value for the whole window and are loaded from the shift register only once select is released. The serial data output presents the top bit of the shift register and changes on falling serial clock edges. This lets several devices share one select line and be chained output-to-input: a stream of sixteen bits leaves the first word in the far device and the second word in the near one.

The sequencing is one state machine with three states. IDLE (deselected) moves to SHIFT on a select falling edge. SHIFT (selected, shifting) moves to COMMIT on a select rising edge. COMMIT (one system clock, loads the enable latch) always returns to IDLE.

Top module: `swl_ctrl_latch`

## Requirements
- R1: After reset, all eight enables are 0 and the serial data output is 0.
- R2: While select is low, each rising serial clock edge shifts the data bit into bit 0 and moves every bit up by one. After eight edges the first bit sent drives enable 7 and the last bit drives enable 0, so enable n equals register bit n.
- R3: While select is low, the enables keep the value they held before the window opened, whatever is shifted in.
- R4: The enables load the shift register contents within 6 system clocks of select rising, whether the serial clock is high or low at that moment.
- R5: With fewer or more than eight rising edges in a window, the enables receive the register as it stands: the last eight bits shifted, with older bits moved up when fewer than eight were sent.
- R6: While selected, the serial data output takes the register's top bit on each falling serial clock edge. It therefore repeats the input stream eight edges late, and two chained devices load the first and second word of a sixteen-bit stream into the far and near device respectively.
- R7: While select is high, serial clock and data transitions do not alter the register, and the serial data output equals the register's top bit.
- R8: Any pattern of enables can be loaded, including all zeros (0x00) and all ones (0xFF), and a single one can be walked across the channels one clock per window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, for chaining |
| sw_en | output | 8 | Registered switch enables, bit n drives switch n |

## Verification
On every cycle, assertions check that the enables hold while the machine is in SHIFT, that COMMIT copies the register into the enables, that the register cannot move outside SHIFT, and that the data output changes only on a falling serial clock edge or while deselected. The bench scenarios are needed for the end-to-end results: the bit order after a full word, the outcome of short and long bursts, the eight-edge echo through a two-device chain, a load taken with the serial clock held high, and a single one walked across the channels. Random words and burst lengths from a fixed seed are checked against a bench model of the shift register.

// File: rtl/swl_pkg.sv
package swl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;

endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/swl_edge.sv
module swl_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level;
        end
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            assign rise[g] = level[g] & ~prev_q[g];
            assign fall[g] = ~level[g] & prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/swl_frame_fsm.sv
module swl_frame_fsm
    import swl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_fall,
    input  logic         cs_rise,
    output frame_state_t state_q,
    output logic         selected,
    output logic         commit
);

    frame_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        selected = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE:   selected = 1'b0;
            ST_SHIFT:  selected = ~cs_rise;
            ST_COMMIT: commit   = 1'b1;
            default:   selected = 1'b0;
        endcase
    end

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE)); // R4

endmodule

// File: rtl/swl_shreg.sv
module swl_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             selected,
    input  logic             shift_pulse,
    input  logic             out_pulse,
    input  logic             din,
    output logic [WIDTH-1:0] shreg_q,
    output logic             dout_q
);

    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (selected && shift_pulse) begin
            shreg_q <= {shreg_q[TOP-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (!selected || out_pulse) begin
            dout_q <= shreg_q[TOP];
        end
    end

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(!selected || out_pulse)); // R6

endmodule

// File: rtl/swl_ctrl_latch.sv
module swl_ctrl_latch
    import swl_pkg::*;
#(
    parameter int N_SW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            sdi,
    output logic            sdo,
    output logic [N_SW-1:0] sw_en
);

    localparam int PIN_CS   = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_SDI  = 0;

    logic [2:0]      pins_s;
    logic [1:0]      edge_rise;
    logic [1:0]      edge_fall;
    frame_state_t    state_q;
    logic            selected;
    logic            commit;
    logic [N_SW-1:0] shreg_q;
    logic [N_SW-1:0] sw_en_q;

    swl_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk, sdi}),
        .sync_out (pins_s)
    );

    swl_edge #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({pins_s[PIN_CS], pins_s[PIN_SCLK]}),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    swl_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (edge_fall[1]),
        .cs_rise  (edge_rise[1]),
        .state_q  (state_q),
        .selected (selected),
        .commit   (commit)
    );

    swl_shreg #(
        .WIDTH (N_SW)
    ) u_shreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .selected    (selected),
        .shift_pulse (edge_rise[0]),
        .out_pulse   (edge_fall[0]),
        .din         (pins_s[PIN_SDI]),
        .shreg_q     (shreg_q),
        .dout_q      (sdo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en_q <= '0;
        end else if (commit) begin
            sw_en_q <= shreg_q;
        end
    end

    assign sw_en = sw_en_q;

    AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |=> $stable(sw_en_q)); // R3

    AST_LOAD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (sw_en_q == $past(shreg_q))); // R4

    AST_FROZEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |=> $stable(shreg_q)); // R7

endmodule

// File: tb/swl_ctrl_latch_tb.sv
module swl_ctrl_latch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo_a;
    logic       sdo_b;
    logic [7:0] en_a;
    logic [7:0] en_b;

    int tests = 0;
    int fails = 0;

    logic [7:0] ma = '0;
    logic [7:0] mb = '0;
    logic [7:0] exp_a = '0;
    logic [7:0] exp_b = '0;

    always #10 clk = ~clk;

    swl_ctrl_latch u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
        .sdi (sdi), .sdo (sdo_a), .sw_en (en_a)
    );

    swl_ctrl_latch u_dut_b (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
        .sdi (sdo_a), .sdo (sdo_b), .sw_en (en_b)
    );

    function automatic logic [7:0] push_bit(input logic [7:0] r, input logic b);
        return {r[6:0], b};
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] bits, input int n,
                              input bit high_end, input bit chk_b);
        logic out;
        cs_n = 1'b0;
        waitc(8);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            waitc(4);
            sclk = 1'b1;
            out = ma[7];
            ma = push_bit(ma, bits[i]);
            mb = push_bit(mb, out);
            waitc(8);
            if (!(high_end && i == 0)) begin
                sclk = 1'b0;
                waitc(4);
                check8("R6 sdo after falling edge", {7'd0, sdo_a}, {7'd0, ma[7]});
            end
        end
        waitc(4);
        check8("R3 enables hold in window", en_a, exp_a);
        cs_n = 1'b1;
        waitc(8);
        exp_a = ma;
        exp_b = mb;
        check8("R2 R5 enables after release", en_a, exp_a);
        check8("R7 sdo holds top bit", {7'd0, sdo_a}, {7'd0, ma[7]});
        if (chk_b) check8("R6 chained device word", en_b, exp_b);
        if (high_end) begin
            sclk = 1'b0;
            waitc(8);
            check8("R4 load with sclk high", en_a, exp_a);
            check8("R7 sdo after ignored fall", {7'd0, sdo_a}, {7'd0, ma[7]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        waitc(5);
        check8("R1 enables in reset", en_a, 8'h00);
        rst_n = 1'b1;
        waitc(5);
        check8("R1 enables after reset", en_a, 8'h00);
        check8("R1 sdo after reset", {7'd0, sdo_a}, 8'h00);

        // R2: full word, first bit lands on enable 7
        send_frame(16'h00A5, 8, 1'b0, 1'b0);
        check8("R2 bit order A5", en_a, 8'hA5);
        send_frame(16'h003C, 8, 1'b0, 1'b0);

        // R8: none and all
        send_frame(16'h00FF, 8, 1'b0, 1'b0);
        check8("R8 all on", en_a, 8'hFF);
        send_frame(16'h0000, 8, 1'b0, 1'b0);
        check8("R8 all off", en_a, 8'h00);

        // R5: short burst keeps older bits shifted up
        send_frame(16'h00C3, 8, 1'b0, 1'b0);
        send_frame(16'h0002, 3, 1'b0, 1'b0);
        check8("R5 short burst", en_a, 8'h1A);
        // R5: long burst keeps the last eight
        send_frame(16'h0F96, 12, 1'b0, 1'b0);
        check8("R5 long burst", en_a, 8'h96);

        // R4: release while sclk is high
        send_frame(16'h005A, 8, 1'b1, 1'b0);
        check8("R4 word with sclk high", en_a, 8'h5A);

        // R7: activity while deselected is ignored
        for (int k = 0; k < 10; k++) begin
            sdi = 1'($urandom);
            waitc(4);
            sclk = 1'b1;
            waitc(8);
            sclk = 1'b0;
            waitc(4);
        end
        check8("R7 enables unchanged while high", en_a, exp_a);
        check8("R7 sdo unchanged while high", {7'd0, sdo_a}, {7'd0, ma[7]});
        send_frame(16'h0000, 0, 1'b0, 1'b0);
        check8("R7 register untouched", en_a, 8'h5A);

        // R6: two-device chain with a sixteen-bit stream
        send_frame(16'h3CE1, 16, 1'b0, 1'b1);
        check8("R6 far device word", en_b, 8'h3C);
        check8("R6 near device word", en_a, 8'hE1);

        // R8: walk a single one across the channels
        send_frame(16'h0001, 8, 1'b0, 1'b0);
        check8("R8 walk start", en_a, 8'h01);
        for (int k = 1; k < 8; k++) begin
            send_frame(16'h0000, 1, 1'b0, 1'b0);
            check8("R8 walking one", en_a, 8'h01 << k);
        end

        // R2 R5: random words and burst lengths
        for (int k = 0; k < 20; k++) begin
            send_frame(16'($urandom), 1 + int'($urandom_range(11)),
                       1'($urandom_range(1)), 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule